// File: doc/BRIEF.md
# Configurable Host Port Slave

This block lets an external host read and write a small file of 16-bit registers inside the chip. Two static mode pins select the bus style the host uses. One pin chooses between a separate 3-bit address with a 16-bit data bus, and a 16-bit multiplexed address/data bus qualified by an address-latch strobe. The other pin chooses between separate active-low read and write strobes, and a single active-low data strobe with a read/write direction line.

All host pins pass through a two-stage synchroniser into the core clock domain. The access strobe and the select are combined into one "cycle active" term. Its rising edge starts a cycle and its falling edge ends one. The port pulls an active-low acknowledge for every cycle. During a read it drives the selected register with an output enable. A write commits the data seen on the bus during the last active cycle, at the end of the cycle.

Top module: `hostport_slave`

## Requirements
- R1: After reset, `hack_n` is 1, `hdoe` is 0 and all eight registers read back as 0.
- R2: With `mode_ds`=0, a cycle with `hsel_n` low and `hstb_a_n` (write strobe) low writes the data bus value into the register picked by the address when the cycle ends.
- R3: During a read cycle (`mode_ds`=0: `hstb_b_n` low), `hdoe` is 1 and `hdout` carries the addressed register. After the cycle ends, `hdoe` returns to 0.
- R4: `hack_n` falls exactly 3 clock edges after the start condition is applied to the pins and rises exactly 3 edges after the end condition is applied. It stays low in between.
- R5: With `mode_ds`=1, a cycle is `hstb_a_n` (data strobe) low with `hsel_n` low. `hstb_b_n`=1 at the start means read and 0 means write.
- R6: With `mode_mux`=1, the address is the low 3 bits of `hdin` as last seen while `hale` was 1. The upper 13 bits are ignored, `haddr` is ignored, and the data comes from `hdin` during the strobe.
- R7: A strobe held low while `hsel_n` is 1 starts no cycle. `hack_n` stays 1 and no register changes.
- R8: Raising `hsel_n` while the strobe is still low ends the cycle. A write ended this way is committed the same as one ended by the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_mux | input | 1 | 0: separate address/data, 1: multiplexed bus with ALE |
| mode_ds | input | 1 | 0: separate read/write strobes, 1: data strobe plus direction |
| hsel_n | input | 1 | Active-low port select |
| hstb_a_n | input | 1 | Write strobe (mode_ds=0) or data strobe (mode_ds=1) |
| hstb_b_n | input | 1 | Read strobe (mode_ds=0) or direction, 1=read (mode_ds=1) |
| hale | input | 1 | Address latch enable, multiplexed mode only |
| haddr | input | 3 | Register address, separate mode only |
| hdin | input | 16 | Host data in, or address/data in multiplexed mode |
| hdout | output | 16 | Read data, valid while hdoe is 1 |
| hdoe | output | 1 | Output enable for the external tri-state driver |
| hack_n | output | 1 | Active-low acknowledge |

## Verification
A wrong cycle state shows at the ports within three clocks of a start or end condition. Either `hack_n` or `hdoe` holds the wrong level at the exact cycle the bench samples. A wrong address latch or a write into the wrong slot stays hidden until that register is read back. For that reason every write is followed, directly or later in the random sequence, by a read that compares all 16 bits against a model register file. Random bus modes are mixed in so that an error specific to one mode cannot hide behind another.

// File: rtl/hp_pkg.sv
package hp_pkg;
    typedef enum logic [1:0] {
        HP_IDLE  = 2'd0,
        HP_READ  = 2'd1,
        HP_WRITE = 2'd2
    } hp_state_e;
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_chain
        always_comb begin
            stage_d[s] = stage_q[s-1];
        end
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_d[s];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/hp_regfile.sv
module hp_regfile #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] rf_q [DEPTH];
    logic [DW-1:0] rf_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) rf_d[i] = rf_q[i];
        if (we) rf_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) rf_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) rf_q[i] <= rf_d[i];
        end
    end

    assign rdata = rf_q[raddr];

    // R2: a write pulse lands in the addressed slot
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> rf_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/hp_ctrl.sv
module hp_ctrl
    import hp_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_mux,
    input  logic          mode_ds,
    input  logic          sel_n,
    input  logic          stb_a_n,
    input  logic          stb_b_n,
    input  logic          ale,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] raddr,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] hdout,
    output logic          hdoe,
    output logic          hack_n
);
    typedef struct packed {
        hp_state_e     state;
        logic          act;
        logic [AW-1:0] addr;
        logic [AW-1:0] alat;
        logic [DW-1:0] wdata;
        logic          we;
    } ctrl_t;

    ctrl_t c_q, c_d;
    logic  act, start, stop, is_read;

    always_comb begin
        if (mode_ds) act = !stb_a_n && !sel_n;
        else         act = (!stb_a_n || !stb_b_n) && !sel_n;
        if (mode_mux && ale) act = 1'b0;
        is_read = mode_ds ? stb_b_n : stb_a_n;
        start   = act && !c_q.act;
        stop    = !act && c_q.act;

        c_d     = c_q;
        c_d.act = act;
        c_d.we  = 1'b0;
        if (ale) c_d.alat = din[AW-1:0];
        if (start) begin
            c_d.state = is_read ? HP_READ : HP_WRITE;
            c_d.addr  = mode_mux ? c_q.alat : addr;
            c_d.wdata = din;
        end else if (act && c_q.state == HP_WRITE) begin
            c_d.wdata = din;
        end
        if (stop) begin
            c_d.state = HP_IDLE;
            c_d.we    = (c_q.state == HP_WRITE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{state: HP_IDLE, act: 1'b0, addr: '0, alat: '0,
                     wdata: '0, we: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign raddr  = c_q.addr;
    assign waddr  = c_q.addr;
    assign wdata  = c_q.wdata;
    assign we     = c_q.we;
    assign hdoe   = (c_q.state == HP_READ);
    assign hdout  = hdoe ? rdata : '0;
    assign hack_n = (c_q.state == HP_IDLE);

    // R3: read data only driven while acknowledging
    p_oe_with_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hdoe |-> !hack_n);
    // R3: read data holds steady through the read
    p_read_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == HP_READ && $past(c_q.state) == HP_READ) |-> $stable(hdout));
    // R2: a commit only follows a write cycle that has just closed
    p_we_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (hack_n && $past(c_q.state) == HP_WRITE));
    // R4: acknowledge released once the active term drops
    p_ack_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(c_q.act) |-> hack_n);
endmodule

// File: rtl/hostport_slave.sv
module hostport_slave #(
    parameter int DW     = 16,
    parameter int DEPTH  = 8,
    parameter int STAGES = 2,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_mux,
    input  logic          mode_ds,
    input  logic          hsel_n,
    input  logic          hstb_a_n,
    input  logic          hstb_b_n,
    input  logic          hale,
    input  logic [AW-1:0] haddr,
    input  logic [DW-1:0] hdin,
    output logic [DW-1:0] hdout,
    output logic          hdoe,
    output logic          hack_n
);
    localparam int CW = 4;
    localparam int BW = AW + DW;

    logic [CW-1:0] ctl_s;
    logic [BW-1:0] bus_s;
    logic          we;
    logic [AW-1:0] waddr, raddr;
    logic [DW-1:0] wdata, rdata;

    hp_sync #(.W(CW), .STAGES(STAGES), .RST_VAL(4'b1110)) i_ctl_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({hsel_n, hstb_a_n, hstb_b_n, hale}),
        .sync_o(ctl_s)
    );

    hp_sync #(.W(BW), .STAGES(STAGES), .RST_VAL('0)) i_bus_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({haddr, hdin}),
        .sync_o(bus_s)
    );

    hp_ctrl #(.DW(DW), .AW(AW)) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .mode_mux(mode_mux), .mode_ds(mode_ds),
        .sel_n(ctl_s[3]), .stb_a_n(ctl_s[2]), .stb_b_n(ctl_s[1]), .ale(ctl_s[0]),
        .addr(bus_s[BW-1:DW]), .din(bus_s[DW-1:0]),
        .rdata(rdata), .raddr(raddr),
        .we(we), .waddr(waddr), .wdata(wdata),
        .hdout(hdout), .hdoe(hdoe), .hack_n(hack_n)
    );

    hp_regfile #(.DW(DW), .DEPTH(DEPTH)) i_rf (
        .clk(clk), .rst_n(rst_n),
        .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rdata)
    );
endmodule

// File: tb/test_hostport_slave.sv
module test_hostport_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_mux = 1'b0, mode_ds = 1'b0;
    logic        hsel_n = 1'b1, hstb_a_n = 1'b1, hstb_b_n = 1'b1, hale = 1'b0;
    logic [2:0]  haddr = '0;
    logic [15:0] hdin = '0;
    logic [15:0] hdout;
    logic        hdoe, hack_n;

    int errors = 0;
    int checks = 0;
    logic [15:0] model [8];

    always #5 clk = ~clk;

    hostport_slave i_hostport_slave (
        .clk(clk), .rst_n(rst_n), .mode_mux(mode_mux), .mode_ds(mode_ds),
        .hsel_n(hsel_n), .hstb_a_n(hstb_a_n), .hstb_b_n(hstb_b_n), .hale(hale),
        .haddr(haddr), .hdin(hdin), .hdout(hdout), .hdoe(hdoe), .hack_n(hack_n)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [15:0] mux_word(logic [2:0] a);
        return {13'($urandom), a};
    endfunction

    task automatic setup_addr(logic [2:0] a);
        if (mode_mux) begin
            haddr = 3'($urandom);
            hdin  = mux_word(a);
            hale  = 1'b1;
            wait_n(2);
            hale  = 1'b0;
            wait_n(2);
        end else begin
            haddr = a;
        end
    endtask

    task automatic host_write(logic [2:0] a, logic [15:0] d, bit end_by_sel);
        setup_addr(a);
        hdin = d;
        if (mode_ds) begin
            hstb_b_n = 1'b0;
            wait_n(1);
        end
        hstb_a_n = 1'b0;
        hsel_n   = 1'b0;
        wait_n(2);
        check("R4 ack not early", hack_n, 1);
        wait_n(1);
        check(mode_ds ? "R5 write ack" : "R2 write ack", hack_n, 0);
        wait_n(2);
        if (end_by_sel) hsel_n = 1'b1;
        else            hstb_a_n = 1'b1;
        wait_n(3);
        check(end_by_sel ? "R8 ack release" : "R4 ack release", hack_n, 1);
        hsel_n = 1'b1; hstb_a_n = 1'b1; hstb_b_n = 1'b1;
        wait_n(2);
        model[a] = d;
    endtask

    task automatic host_read(logic [2:0] a, string req);
        setup_addr(a);
        if (mode_ds) begin
            hstb_b_n = 1'b1;
            wait_n(1);
            hstb_a_n = 1'b0;
        end else begin
            hstb_b_n = 1'b0;
        end
        hsel_n = 1'b0;
        wait_n(3);
        check({req, " read ack"}, hack_n, 0);
        check({req, " read oe"}, hdoe, 1);
        check({req, " read data"}, hdout, model[a]);
        hsel_n = 1'b1; hstb_a_n = 1'b1; hstb_b_n = 1'b1;
        wait_n(3);
        check("R3 oe released", hdoe, 0);
        check("R4 ack released", hack_n, 1);
        wait_n(1);
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 8; i++) model[i] = '0;
        wait_n(3);
        check("R1 ack reset", hack_n, 1);
        check("R1 oe reset", hdoe, 0);
        rst_n = 1'b1;
        wait_n(2);
        for (int i = 0; i < 8; i++) host_read(3'(i), "R1");

        // separate address, separate strobes
        mode_mux = 0; mode_ds = 0;
        host_write(3'd5, 16'hA55A, 0);
        host_read(3'd5, "R2");
        host_write(3'd0, 16'hFFFF, 1);
        host_read(3'd0, "R8");
        host_read(3'd7, "R3");

        // strobe without select ignored
        hstb_a_n = 0; hdin = 16'h1234; haddr = 3'd5;
        wait_n(6);
        check("R7 no ack", hack_n, 1);
        hstb_a_n = 1;
        wait_n(2);
        host_read(3'd5, "R7");

        // data strobe with direction
        mode_ds = 1;
        host_write(3'd3, 16'h0F0F, 0);
        host_read(3'd3, "R5");

        // multiplexed bus
        mode_mux = 1; mode_ds = 0;
        host_write(3'd6, 16'hBEEF, 0);
        host_read(3'd6, "R6");
        mode_ds = 1;
        host_write(3'd1, 16'h8001, 1);
        host_read(3'd1, "R6");

        for (int n = 0; n < 60; n++) begin
            logic [2:0] a;
            mode_mux = 1'($urandom);
            mode_ds  = 1'($urandom);
            a = 3'($urandom);
            if ($urandom % 2) host_write(a, 16'($urandom), 1'($urandom));
            else              host_read(a, "R6 random");
        end
        for (int i = 0; i < 8; i++) host_read(3'(i), "R2 final");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule